// File: doc/BRIEF.md
# One-Time-Programmable Station Address Fuse Controller

This block fronts a one-time-programmable fuse array that holds a 48-bit station address. Software works it through two 32-bit control words. The first word takes a command, a bit address and an execute strobe, and it returns status. The second word holds a soft reset bit. Three commands exist:

- **Autoload** checks the array and copies the stored address into two read-only MAC address registers.
- **Single-bit read** returns the value of one fuse bit.
- **Blow** sets one fuse bit for good.

The execute bit stays high while a command is running. It drops by itself on the cycle the command completes. The fuse array is a behavioural model inside the block, and a hardware reset clears it to all zeros (unprogrammed). Its layout is as follows:

- Bytes 0 to 5 hold the address.
- Byte 6 holds a check byte.
- Bit 0 of byte 7 marks the array as programmed.

Top module: `efuse_ctrl_top`

## Requirements
- R1: After hardware reset, both control words read 0, both MAC address outputs are 0 and every fuse bit reads 0.
- R2: A write to control word 1 (regWrSel=0) with bit 27 set and a nonzero command in bits 26:25 starts that command. Command 01 is autoload, 10 is read and 11 is blow. Bit 27 reads 1 while the command runs and reads 0 on the same cycle the autoload done flag (bit 0) rises. Bit 27 written with command 00 starts nothing.
- R3: An autoload runs for exactly LOAD_CYCLES clock cycles, counted from the write edge. The default of 13500 cycles is 108 µs at 125 MHz. Starting an autoload clears bit 0 and bit 16.
- R4: An autoload on a valid array sets bit 0 and clears bit 16. The array is valid when bit 0 of fuse byte 7 is 1 and fuse byte 6 equals the XOR of fuse bytes 0 to 5. On success, macAddrLo = {byte3, byte2, byte1, byte0} and macAddrHi = {16'h0, byte5, byte4}.
- R5: An autoload on an invalid array sets both bit 0 and bit 16 and leaves both MAC address outputs unchanged. An unprogrammed array is invalid, and so is an array with a bad check byte.
- R6: A read command returns, after ACCESS_CYCLES cycles, the selected fuse bit in bit 28 of control word 1, with bits 31:29 set to 0. Bits 15:8 select the byte and bits 6:4 select the bit. The read leaves bits 0 and 16 unchanged.
- R7: A blow command sets the selected fuse bit after ACCESS_CYCLES cycles. No command ever clears a fuse bit. Blowing a bit that is already set changes nothing.
- R8: A write to control word 1 while bit 27 reads 1 is ignored: the command, the selects and the running command are all kept.
- R9: Bit 15 of control word 2 (regWrSel=1) acts as a soft reset. One cycle after it is written to 1, it has aborted any running command and cleared bits 27, 16, 0 and 31:28. While it stays 1, writes to control word 1 are ignored. The fuse array and the MAC address outputs are not touched by it.
- R10: A byte select of FUSE_BYTES or more addresses no fuse. A read there returns 0 and a blow there changes no fuse bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low hardware reset |
| regWrEn | input | 1 | Register write strobe |
| regWrSel | input | 1 | Write target: 0 control word 1, 1 control word 2 |
| regWrData | input | 32 | Write data |
| regRdSel | input | 1 | Read target: 0 control word 1, 1 control word 2 |
| regRdData | output | 32 | Read data of the selected control word |
| macAddrLo | output | 32 | Address bytes 3..0 loaded by autoload |
| macAddrHi | output | 32 | Address bytes 5..4 in bits 15:0 |

## Verification
The bench builds the block with LOAD_CYCLES=20, ACCESS_CYCLES=3 and FUSE_BYTES=8.

- The short autoload latency lets the bench pin the exact cycle on which the execute bit drops and the done flag rises.
- The three-cycle access keeps it cheap to program a full address bit by bit through blow commands.
- With an eight-byte array, byte select 8 is the first select past the end. If addressing wrapped, it would alias onto byte 0, so it makes out-of-range aliasing directly observable.

// File: rtl/efuse_pkg.sv
package efuse_pkg;

  typedef enum logic [1:0] {
    CMD_NONE = 2'b00,
    CMD_LOAD = 2'b01,
    CMD_READ = 2'b10,
    CMD_BLOW = 2'b11
  } fuseCmd_e;

  typedef struct packed {
    logic acceptCfg;
    logic startLoad;
    logic finishLoad;
    logic finishRead;
    logic finishBlow;
    logic softClr;
  } fuseStrb_t;

  localparam int EXEC_BIT  = 27;
  localparam int CMD_LSB   = 25;
  localparam int ERR_BIT   = 16;
  localparam int DONE_BIT  = 0;
  localparam int SRST_BIT  = 15;
  localparam int PAR_BYTE  = 6;
  localparam int MARK_BYTE = 7;
  localparam int ADDR_BYTES = 6;

endpackage

// File: rtl/efuse_ctrl.sv
module efuse_ctrl
  import efuse_pkg::*;
#(
  parameter int LOAD_CYCLES   = 13500,
  parameter int ACCESS_CYCLES = 4
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      wrCtrl1,
  input  logic      wrExec,
  input  logic [1:0] wrCmd,
  input  logic      softRst,
  output logic      busy,
  output fuseStrb_t strb
);

  localparam int MAX_CYC = (LOAD_CYCLES > ACCESS_CYCLES) ? LOAD_CYCLES : ACCESS_CYCLES;
  localparam int CNT_W   = $clog2(MAX_CYC + 1);

  logic [CNT_W-1:0] cnt;
  fuseCmd_e activeCmd;
  fuseCmd_e newCmd;
  logic canAccept, launch, lastCycle;

  always_comb begin
    newCmd    = fuseCmd_e'(wrCmd);
    canAccept = wrCtrl1 && !busy && !softRst;
    launch    = canAccept && wrExec && (newCmd != CMD_NONE);
    lastCycle = busy && !softRst && (cnt == '0);
    strb            = '0;
    strb.acceptCfg  = canAccept;
    strb.startLoad  = launch && (newCmd == CMD_LOAD);
    strb.finishLoad = lastCycle && (activeCmd == CMD_LOAD);
    strb.finishRead = lastCycle && (activeCmd == CMD_READ);
    strb.finishBlow = lastCycle && (activeCmd == CMD_BLOW);
    strb.softClr    = softRst;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy      <= 1'b0;
      cnt       <= '0;
      activeCmd <= CMD_NONE;
    end else if (softRst) begin
      busy <= 1'b0;
      cnt  <= '0;
    end else if (launch) begin
      busy      <= 1'b1;
      activeCmd <= newCmd;
      cnt       <= (newCmd == CMD_LOAD) ? CNT_W'(LOAD_CYCLES - 1) : CNT_W'(ACCESS_CYCLES - 1);
    end else if (busy) begin
      if (cnt == '0) busy <= 1'b0;
      else           cnt  <= cnt - 1'b1;
    end
  end

  // Independent age counter for the autoload latency bound.
  logic [CNT_W:0] loadAge;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                           loadAge <= '0;
    else if (launch)                     loadAge <= '0;
    else if (busy && activeCmd == CMD_LOAD) loadAge <= loadAge + 1'b1;
  end

  // R3: an autoload never stays busy past its cycle budget
  a_r3_load_bound: assert property (@(posedge clk) disable iff (!rstN)
    (busy && activeCmd == CMD_LOAD) |-> (loadAge < (CNT_W+1)'(LOAD_CYCLES)));

  // R9: soft reset drops the execute state on the next edge
  a_r9_abort: assert property (@(posedge clk) disable iff (!rstN)
    softRst |=> !busy);

endmodule

// File: rtl/efuse_dp.sv
module efuse_dp
  import efuse_pkg::*;
#(
  parameter int FUSE_BYTES = 8
) (
  input  logic        clk,
  input  logic        rstN,
  input  fuseStrb_t   strb,
  input  logic        busy,
  input  logic        wrCtrl2,
  input  logic [31:0] wrData,
  output logic        softRst,
  output logic [31:0] ctrl1Val,
  output logic [31:0] ctrl2Val,
  output logic [31:0] macLo,
  output logic [31:0] macHi
);

  localparam int FUSE_BITS = FUSE_BYTES * 8;

  logic [FUSE_BITS-1:0] fuse;
  logic [7:0]  byteSel;
  logic [2:0]  bitSel;
  logic [1:0]  cmdField;
  logic [3:0]  dataNib;
  logic        doneFlag, errFlag, rstBit;
  logic [10:0] bitAddr;
  logic        fuseBit, arrayOk;
  logic [7:0]  xorAcc;

  assign bitAddr = {byteSel, bitSel};
  assign softRst = rstBit;

  always_comb begin
    fuseBit = 1'b0;
    for (int i = 0; i < FUSE_BITS; i++)
      if (bitAddr == 11'(i)) fuseBit = fuse[i];
    xorAcc = '0;
    for (int k = 0; k < ADDR_BYTES; k++)
      xorAcc = xorAcc ^ fuse[k*8 +: 8];
    arrayOk = fuse[MARK_BYTE*8] && (xorAcc == fuse[PAR_BYTE*8 +: 8]);
  end

  generate
    for (genvar i = 0; i < FUSE_BITS; i++) begin : g_fuse
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) fuse[i] <= 1'b0;
        else if (strb.finishBlow && bitAddr == 11'(i)) fuse[i] <= 1'b1;
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      byteSel <= '0; bitSel <= '0; cmdField <= '0; dataNib <= '0;
      doneFlag <= 1'b0; errFlag <= 1'b0; rstBit <= 1'b0;
      macLo <= '0; macHi <= '0;
    end else begin
      if (wrCtrl2) rstBit <= wrData[SRST_BIT];
      if (strb.softClr) begin
        doneFlag <= 1'b0;
        errFlag  <= 1'b0;
        dataNib  <= '0;
      end else begin
        if (strb.acceptCfg) begin
          byteSel  <= wrData[15:8];
          bitSel   <= wrData[6:4];
          cmdField <= wrData[CMD_LSB +: 2];
        end
        if (strb.startLoad) begin
          doneFlag <= 1'b0;
          errFlag  <= 1'b0;
        end
        if (strb.finishLoad) begin
          doneFlag <= 1'b1;
          errFlag  <= !arrayOk;
          if (arrayOk) begin
            macLo <= fuse[31:0];
            macHi <= {16'h0, fuse[47:32]};
          end
        end
        if (strb.finishRead) dataNib <= {3'b000, fuseBit};
      end
    end
  end

  assign ctrl1Val = {dataNib, busy, cmdField, 8'h00, errFlag, byteSel,
                     1'b0, bitSel, 3'b000, doneFlag};
  assign ctrl2Val = 32'(rstBit) << SRST_BIT;

  // R7: fuse bits are never cleared
  a_r7_fuse_monotone: assert property (@(posedge clk) disable iff (!rstN)
    (($past(fuse) & ~fuse) == '0));

  // R5: the address registers move only on a successful autoload
  a_r5_mac_hold: assert property (@(posedge clk) disable iff (!rstN)
    (macLo != $past(macLo) || macHi != $past(macHi)) |-> ($past(strb.finishLoad) && !errFlag));

  // R9: soft reset clears the status flags
  a_r9_flags_clear: assert property (@(posedge clk) disable iff (!rstN)
    rstBit |=> (!doneFlag && !errFlag));

endmodule

// File: rtl/efuse_ctrl_top.sv
module efuse_ctrl_top
  import efuse_pkg::*;
#(
  parameter int FUSE_BYTES    = 8,
  parameter int LOAD_CYCLES   = 13500,
  parameter int ACCESS_CYCLES = 4
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        regWrEn,
  input  logic        regWrSel,
  input  logic [31:0] regWrData,
  input  logic        regRdSel,
  output logic [31:0] regRdData,
  output logic [31:0] macAddrLo,
  output logic [31:0] macAddrHi
);

  fuseStrb_t   strb;
  logic        busy, softRst;
  logic [31:0] ctrl1Val, ctrl2Val;

  efuse_ctrl #(
    .LOAD_CYCLES  (LOAD_CYCLES),
    .ACCESS_CYCLES(ACCESS_CYCLES)
  ) u_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .wrCtrl1(regWrEn && !regWrSel),
    .wrExec (regWrData[EXEC_BIT]),
    .wrCmd  (regWrData[CMD_LSB +: 2]),
    .softRst(softRst),
    .busy   (busy),
    .strb   (strb)
  );

  efuse_dp #(
    .FUSE_BYTES(FUSE_BYTES)
  ) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .strb    (strb),
    .busy    (busy),
    .wrCtrl2 (regWrEn && regWrSel),
    .wrData  (regWrData),
    .softRst (softRst),
    .ctrl1Val(ctrl1Val),
    .ctrl2Val(ctrl2Val),
    .macLo   (macAddrLo),
    .macHi   (macAddrHi)
  );

  assign regRdData = regRdSel ? ctrl2Val : ctrl1Val;

  // R2: execute is already low when done rises
  a_r2_exec_drop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(ctrl1Val[DONE_BIT]) |-> !ctrl1Val[EXEC_BIT]);

  // R8: a write while executing leaves command and selects untouched
  a_r8_busy_write_ignored: assert property (@(posedge clk) disable iff (!rstN)
    (ctrl1Val[EXEC_BIT] && regWrEn && !regWrSel) |=>
      ($stable(ctrl1Val[26:25]) && $stable(ctrl1Val[15:4])));

endmodule

// File: tb/tb_efuse_ctrl_top.sv
module tb_efuse_ctrl_top;

  localparam int LOADC = 20;
  localparam int ACCC  = 3;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        regWrEn = 1'b0;
  logic        regWrSel = 1'b0;
  logic [31:0] regWrData = '0;
  logic        regRdSel = 1'b0;
  logic [31:0] regRdData, macAddrLo, macAddrHi;

  int nChecks = 0;
  int nFails  = 0;
  bit finished = 0;

  logic [7:0] addr [6] = '{8'h02, 8'h1A, 8'h3C, 8'h4D, 8'h5E, 8'h6F};
  logic [7:0] parity;
  logic [31:0] expLo, expHi;

  efuse_ctrl_top #(.FUSE_BYTES(8), .LOAD_CYCLES(LOADC), .ACCESS_CYCLES(ACCC)) dut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regWrSel(regWrSel),
    .regWrData(regWrData), .regRdSel(regRdSel), .regRdData(regRdData),
    .macAddrLo(macAddrLo), .macAddrHi(macAddrHi));

  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(logic exec, logic [1:0] cmd, logic [7:0] b, logic [2:0] bi);
    return (32'(exec) << 27) | (32'(cmd) << 25) | (32'(b) << 8) | (32'(bi) << 4);
  endfunction

  task automatic wr(logic sel, logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regWrSel = sel; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic rd(logic sel, output logic [31:0] d);
    regRdSel = sel;
    #1;
    d = regRdData;
  endtask

  task automatic blowBit(logic [7:0] b, logic [2:0] bi);
    wr(0, mk(1, 2'b11, b, bi));
    repeat (ACCC) @(negedge clk);
  endtask

  task automatic blowByte(logic [7:0] b, logic [7:0] v);
    for (int i = 0; i < 8; i++)
      if (v[i]) blowBit(b, 3'(i));
  endtask

  task automatic readBit(logic [7:0] b, logic [2:0] bi, output logic [31:0] c1);
    wr(0, mk(1, 2'b10, b, bi));
    repeat (ACCC) @(negedge clk);
    rd(0, c1);
  endtask

  task automatic runLoad(output logic [31:0] c1);
    wr(0, mk(1, 2'b01, 8'h00, 3'd0));
    repeat (LOADC) @(negedge clk);
    rd(0, c1);
  endtask

  task automatic t_reset;
    logic [31:0] v;
    rd(0, v); chk("R1 ctrl1 after reset", v, 32'h0);
    rd(1, v); chk("R1 ctrl2 after reset", v, 32'h0);
    chk("R1 macLo after reset", macAddrLo, 32'h0);
    chk("R1 macHi after reset", macAddrHi, 32'h0);
    readBit(8'd3, 3'd5, v); chk("R1 fuse bit blank", {31'h0, v[28]}, 32'h0);
  endtask

  task automatic t_blank_load;
    logic [31:0] v;
    wr(0, mk(1, 2'b01, 8'h00, 3'd0));
    rd(0, v); chk("R2 exec high at start", {31'h0, v[27]}, 32'h1);
    chk("R3 done cleared at start", {31'h0, v[0]}, 32'h0);
    repeat (LOADC - 1) @(negedge clk);
    rd(0, v); chk("R3 still busy one cycle before end", {30'h0, v[27], v[0]}, 32'h2);
    @(negedge clk);
    rd(0, v); chk("R2 exec clear with done", {30'h0, v[27], v[0]}, 32'h1);
    chk("R5 blank array error", {31'h0, v[16]}, 32'h1);
    chk("R5 macLo kept on blank", macAddrLo, 32'h0);
  endtask

  task automatic t_bad_parity;
    logic [31:0] v;
    for (int k = 0; k < 6; k++) blowByte(8'(k), addr[k]);
    blowBit(8'd7, 3'd0);
    runLoad(v);
    chk("R5 bad check byte error", {30'h0, v[16], v[0]}, 32'h3);
    chk("R5 macLo kept on bad parity", macAddrLo, 32'h0);
    chk("R5 macHi kept on bad parity", macAddrHi, 32'h0);
  endtask

  task automatic t_good_load;
    logic [31:0] v;
    blowByte(8'd6, parity);
    runLoad(v);
    chk("R4 success flags", {30'h0, v[16], v[0]}, 32'h1);
    chk("R4 macLo byte order", macAddrLo, expLo);
    chk("R4 macHi byte order", macAddrHi, expHi);
  endtask

  task automatic t_read;
    logic [31:0] v;
    readBit(8'd1, 3'd3, v);
    chk("R6 read set bit", v[31:28], 32'h1);
    chk("R6 read keeps done and error", {30'h0, v[16], v[0]}, 32'h1);
    readBit(8'd1, 3'd2, v);
    chk("R6 read clear bit", v[31:28], 32'h0);
    chk("R2 exec clear after read", {31'h0, v[27]}, 32'h0);
  endtask

  task automatic t_reblow;
    logic [31:0] v;
    blowBit(8'd2, 3'd2);
    readBit(8'd2, 3'd2, v); chk("R7 reblown bit stays 1", v[31:28], 32'h1);
    readBit(8'd2, 3'd1, v); chk("R7 neighbour untouched", v[31:28], 32'h0);
  endtask

  task automatic t_range;
    logic [31:0] v;
    blowBit(8'd8, 3'd0);
    readBit(8'd8, 3'd0, v); chk("R10 out-of-range read is 0", v[31:28], 32'h0);
    readBit(8'd0, 3'd0, v); chk("R10 no alias onto byte 0", v[31:28], 32'h0);
  endtask

  task automatic t_cmd_none;
    logic [31:0] v;
    wr(0, mk(1, 2'b00, 8'h00, 3'd0));
    rd(0, v); chk("R2 command 00 does not start", {31'h0, v[27]}, 32'h0);
  endtask

  task automatic t_busy_write;
    logic [31:0] v;
    wr(0, mk(1, 2'b01, 8'h00, 3'd0));
    wr(0, mk(1, 2'b10, 8'h05, 3'd6));
    rd(0, v);
    chk("R8 selects kept while busy", {16'h0, v[15:8], 1'b0, v[6:4], 4'h0}, 32'h0);
    chk("R8 command kept while busy", {29'h0, v[27:25]}, 32'h5);
    repeat (LOADC - 1) @(negedge clk);
    rd(0, v);
    chk("R8 autoload completes normally", {30'h0, v[27], v[0]}, 32'h1);
    chk("R8 macLo after ignored write", macAddrLo, expLo);
  endtask

  task automatic t_soft_reset;
    logic [31:0] v;
    wr(0, mk(1, 2'b01, 8'h00, 3'd0));
    repeat (3) @(negedge clk);
    wr(1, 32'h0000_8000);
    @(negedge clk);
    rd(0, v); chk("R9 abort clears exec/err/done", {29'h0, v[27], v[16], v[0]}, 32'h0);
    rd(1, v); chk("R9 reset bit reads back", v, 32'h0000_8000);
    wr(0, mk(1, 2'b01, 8'h00, 3'd0));
    rd(0, v); chk("R9 start ignored in reset", {31'h0, v[27]}, 32'h0);
    wr(1, 32'h0);
    repeat (LOADC + 2) @(negedge clk);
    rd(0, v); chk("R9 nothing ran", {31'h0, v[0]}, 32'h0);
    chk("R9 macLo untouched", macAddrLo, expLo);
    readBit(8'd0, 3'd1, v); chk("R9 fuse untouched", v[31:28], 32'h1);
  endtask

  task automatic t_corrupt_after_good;
    logic [31:0] v;
    blowBit(8'd6, 3'd0);
    runLoad(v);
    chk("R5 corrupted array error", {30'h0, v[16], v[0]}, 32'h3);
    chk("R5 macLo retains good value", macAddrLo, expLo);
    chk("R5 macHi retains good value", macAddrHi, expHi);
  endtask

  initial begin
    parity = '0;
    for (int k = 0; k < 6; k++) parity = parity ^ addr[k];
    expLo = {addr[3], addr[2], addr[1], addr[0]};
    expHi = {16'h0, addr[5], addr[4]};
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    t_reset();
    t_blank_load();
    t_bad_parity();
    t_good_load();
    t_read();
    t_reblow();
    t_range();
    t_cmd_none();
    t_busy_write();
    t_soft_reset();
    t_corrupt_after_good();
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      nChecks++;
      nFails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
      $finish;
    end
  end

endmodule